// File: doc/BRIEF.md
# Alternate-Master Bus Arbitration Requester

This block lets a secondary bus master borrow a shared bus that a processor normally owns. The handshake has three wires. The block pulls a shared, wire-ORed bus request line low. It waits for the processor's grant. It then claims the bus by pulling the shared grant-acknowledge line low, but only once the bus is seen to be quiet. The block keeps the bus for as long as its internal transfer engine needs it. When the engine signals completion, the block lets go and passes through a short release state.

All bus-side inputs are active low and come from another clock domain. Each one passes through a two-flop synchronizer before the state machine looks at it. Both outgoing lines are open-drain. The block only ever gives a "pull low" enable, and the pad or the board pull-up supplies the released level. A mode input selects two-wire operation. In that mode the request line also stands in for grant acknowledge, so it stays pulled low for the whole time the block owns the bus.

Top module: `busArbRequester`

## Requirements
- R1: While reset is asserted and at the first sample after reset, brPullLow, bgackPullLow and ownsBus are all 0.
- R2: From idle, brPullLow goes to 1 on the first clock edge at which reqIn is sampled high. The block never drives the request line high; it only enables a low drive.
- R3: bgN, asN, dtackN and bgackLineN each pass through two synchronizer flops. When a grant arrives while the bus is idle, bgackPullLow rises on the fourth clock edge after bgN falls, and not before.
- R4: bgackPullLow rises only when, in the synchronized view, all four of these hold: grant is active (bgN low), asN is high, dtackN is high and bgackLineN is high.
- R5: While holding a grant, the block does not claim the bus for as long as asN is low, dtackN is low or another master holds bgackLineN low.
- R6: In one-wire mode (twoWireMode = 0), brPullLow returns to 0 on the clock edge after the one that raised bgackPullLow.
- R7: Once raised, bgackPullLow stays 1 until doneIn is sampled high, and it falls on that edge. ownsBus equals bgackPullLow at all times.
- R8: After bgackPullLow falls, brPullLow stays 0 on the next edge as well. A new request can raise brPullLow no earlier than the second edge after the release.
- R9: If reqIn drops before the bus is claimed, brPullLow returns to 0 on the next edge and the bus is never claimed.
- R10: If the synchronized grant disappears while the block is waiting for an idle bus, the block keeps brPullLow at 1 and returns to waiting for a grant.
- R11: In two-wire mode (twoWireMode = 1), brPullLow is 1 while a request is pending or while bgackPullLow is 1. It falls on the same edge as bgackPullLow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| twoWireMode | input | 1 | 1 folds grant acknowledge into the request line; change only while idle |
| reqIn | input | 1 | Internal request for the bus, active high |
| doneIn | input | 1 | Internal transfer finished, active high |
| bgN | input | 1 | Bus grant from the current master, active low, asynchronous |
| asN | input | 1 | Address strobe, active low, asynchronous |
| dtackN | input | 1 | Data transfer acknowledge, active low, asynchronous |
| bgackLineN | input | 1 | Observed level of the shared grant-acknowledge line, active low |
| brPullLow | output | 1 | 1 pulls the shared bus request line low |
| bgackPullLow | output | 1 | 1 pulls the shared grant-acknowledge line low |
| ownsBus | output | 1 | 1 while this block is bus master |

## Verification
Directed sequences give the claim path a grant on an idle bus and count the exact edge on which acknowledge appears. They then hold the grant while address strobe is low, and again while another master holds acknowledge, to separate "grant seen" from "bus free". Further sequences withdraw the request before the grant arrives and take the grant away while the block waits for an idle bus, which tells a clean abort apart from a stuck request. A seeded random phase in each mode then toggles grant, strobe, acknowledge, foreign acknowledge, request and done independently. These runs are compared every cycle with a cycle-level expectation model that includes the synchronizer delay, which exposes ordering errors between claim, request release and the release state.

// File: rtl/arbReqPkg.sv
package arbReqPkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_REQUEST   = 3'd1,
    ST_WAIT_IDLE = 3'd2,
    ST_OWN       = 3'd3,
    ST_RELEASE   = 3'd4
  } arbState_t;

  // Strobes from the control FSM to the output datapath
  typedef struct packed {
    logic setBr;
    logic clrBr;
    logic setBgack;
    logic clrBgack;
  } arbStrobe_t;

  // Bit positions in the synchronized input vector
  localparam int SYNC_BG    = 3;
  localparam int SYNC_AS    = 2;
  localparam int SYNC_DTACK = 1;
  localparam int SYNC_BGACK = 0;
  localparam int SYNC_WIDTH = 4;

endpackage

// File: rtl/arbReqSync.sv
module arbReqSync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stageQ [STAGES];

  initial begin
    if (STAGES < 2) $error("arbReqSync needs at least two stages");
  end

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[0] <= RESET_VAL;
          else       stageQ[0] <= asyncIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[g] <= RESET_VAL;
          else       stageQ[g] <= stageQ[g-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[LAST];

endmodule

// File: rtl/arbReqCtrl.sv
module arbReqCtrl
  import arbReqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqIn,
  input  logic       doneIn,
  input  logic       grantAct,
  input  logic       strobeAct,
  input  logic       dtackAct,
  input  logic       lineBusy,
  output arbStrobe_t strb
);

  arbState_t stateQ, stateD;
  logic busQuiet;

  assign busQuiet = !strobeAct && !dtackAct && !lineBusy;

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqIn) begin
          strb.setBr = 1'b1;
          stateD     = ST_REQUEST;
        end
      end
      ST_REQUEST: begin
        if (!reqIn) begin
          strb.clrBr = 1'b1;
          stateD     = ST_IDLE;
        end else if (grantAct) begin
          stateD = ST_WAIT_IDLE;
        end
      end
      ST_WAIT_IDLE: begin
        if (!reqIn) begin
          strb.clrBr = 1'b1;
          stateD     = ST_IDLE;
        end else if (!grantAct) begin
          stateD = ST_REQUEST;
        end else if (busQuiet) begin
          strb.setBgack = 1'b1;
          stateD        = ST_OWN;
        end
      end
      ST_OWN: begin
        strb.clrBr = 1'b1;
        if (doneIn) begin
          strb.clrBgack = 1'b1;
          stateD        = ST_RELEASE;
        end
      end
      ST_RELEASE: begin
        stateD = ST_IDLE;
      end
      default: begin
        stateD = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  AST_LOST_GRANT_REWAITS: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT_IDLE && reqIn && !grantAct) |=> (stateQ == ST_REQUEST)) else $error("lost grant"); // R10

  AST_RELEASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RELEASE) |=> (stateQ == ST_IDLE)) else $error("release too long"); // R8

endmodule

// File: rtl/arbReqDp.sv
module arbReqDp
  import arbReqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       twoWireMode,
  input  arbStrobe_t strb,
  output logic       brPullLow,
  output logic       bgackPullLow,
  output logic       ownsBus
);

  logic brQ, bgackQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brQ <= 1'b0;
    end else if (strb.clrBr) begin
      brQ <= 1'b0;
    end else if (strb.setBr) begin
      brQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bgackQ <= 1'b0;
    end else if (strb.clrBgack) begin
      bgackQ <= 1'b0;
    end else if (strb.setBgack) begin
      bgackQ <= 1'b1;
    end
  end

  assign brPullLow    = brQ || (twoWireMode && bgackQ);
  assign bgackPullLow = bgackQ;
  assign ownsBus      = bgackQ;

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.setBgack && strb.clrBgack)) else $error("set and clear together"); // R7

  AST_BR_DROPS_AFTER_CLAIM: assert property (@(posedge clk) disable iff (!rstN)
    (!twoWireMode && bgackQ && $past(bgackQ)) |-> !brQ) else $error("request held while owning"); // R6

endmodule

// File: rtl/busArbRequester.sv
module busArbRequester
  import arbReqPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic twoWireMode,
  input  logic reqIn,
  input  logic doneIn,
  input  logic bgN,
  input  logic asN,
  input  logic dtackN,
  input  logic bgackLineN,
  output logic brPullLow,
  output logic bgackPullLow,
  output logic ownsBus
);

  logic [SYNC_WIDTH-1:0] rawVec, syncVec;
  arbStrobe_t strb;
  logic grantAct, strobeAct, dtackAct, lineBusy;

  always_comb begin
    rawVec             = '1;
    rawVec[SYNC_BG]    = bgN;
    rawVec[SYNC_AS]    = asN;
    rawVec[SYNC_DTACK] = dtackN;
    rawVec[SYNC_BGACK] = bgackLineN;
  end

  arbReqSync #(
    .WIDTH(SYNC_WIDTH),
    .STAGES(SYNC_STAGES),
    .RESET_VAL({SYNC_WIDTH{1'b1}})
  ) u_sync (
    .clk(clk),
    .rstN(rstN),
    .asyncIn(rawVec),
    .syncOut(syncVec)
  );

  assign grantAct  = !syncVec[SYNC_BG];
  assign strobeAct = !syncVec[SYNC_AS];
  assign dtackAct  = !syncVec[SYNC_DTACK];
  assign lineBusy  = !syncVec[SYNC_BGACK];

  arbReqCtrl u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .reqIn(reqIn),
    .doneIn(doneIn),
    .grantAct(grantAct),
    .strobeAct(strobeAct),
    .dtackAct(dtackAct),
    .lineBusy(lineBusy),
    .strb(strb)
  );

  arbReqDp u_dp (
    .clk(clk),
    .rstN(rstN),
    .twoWireMode(twoWireMode),
    .strb(strb),
    .brPullLow(brPullLow),
    .bgackPullLow(bgackPullLow),
    .ownsBus(ownsBus)
  );

  AST_CLAIM_ONLY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bgackPullLow) |-> $past(grantAct && !strobeAct && !dtackAct && !lineBusy)) else $error("claimed busy bus"); // R4

  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(bgackPullLow) && !$past(doneIn)) |-> bgackPullLow) else $error("dropped early"); // R7

  AST_GAP_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bgackPullLow) |=> !brPullLow) else $error("request too soon"); // R8

  AST_BR_SET_FROM_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(brPullLow) |-> $past(reqIn)) else $error("request without cause"); // R2

endmodule

// File: tb/busArbRequester_tb.sv
`timescale 1ns/1ps
module busArbRequester_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic twoWireMode = 1'b0;
  logic reqIn = 1'b0, doneIn = 1'b0;
  logic bgN = 1'b1, asN = 1'b1, dtackN = 1'b1, otherBgack = 1'b0;
  logic bgackLineN;
  logic brPullLow, bgackPullLow, ownsBus;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  assign bgackLineN = !(bgackPullLow || otherBgack);

  busArbRequester u_dut (
    .clk(clk), .rstN(rstN), .twoWireMode(twoWireMode),
    .reqIn(reqIn), .doneIn(doneIn), .bgN(bgN), .asN(asN), .dtackN(dtackN),
    .bgackLineN(bgackLineN), .brPullLow(brPullLow),
    .bgackPullLow(bgackPullLow), .ownsBus(ownsBus)
  );

  // Expectation model built from the requirements: 0 idle, 1 request,
  // 2 waiting for quiet bus, 3 owning, 4 release
  logic [3:0] mS1 = 4'hF, mS2 = 4'hF;
  int   mState = 0;
  logic mBr = 1'b0, mBg = 1'b0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 <= 4'hF; mS2 <= 4'hF; mState <= 0; mBr <= 1'b0; mBg <= 1'b0;
    end else begin
      logic gnt, quiet;
      int ns; logic nBr, nBg;
      gnt = !mS2[3];
      quiet = mS2[2] && mS2[1] && mS2[0];
      ns = mState; nBr = mBr; nBg = mBg;
      case (mState)
        0: if (reqIn) begin ns = 1; nBr = 1'b1; end
        1: if (!reqIn) begin ns = 0; nBr = 1'b0; end
           else if (gnt) ns = 2;
        2: if (!reqIn) begin ns = 0; nBr = 1'b0; end
           else if (!gnt) ns = 1;
           else if (quiet) begin ns = 3; nBg = 1'b1; end
        3: begin nBr = 1'b0; if (doneIn) begin ns = 4; nBg = 1'b0; end end
        default: ns = 0;
      endcase
      mS1 <= {bgN, asN, dtackN, bgackLineN};
      mS2 <= mS1;
      mState <= ns; mBr <= nBr; mBg <= nBg;
    end
  end

  function automatic logic expBr(input logic br, input logic bg, input logic tw);
    return br || (tw && bg);
  endfunction

  task automatic checkBit(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareModel();
    string brTag;
    brTag = twoWireMode ? "R11" : (mBg ? "R6" : "R2");
    checkBit(brTag, "brPullLow", brPullLow, expBr(mBr, mBg, twoWireMode));
    checkBit("R4", "bgackPullLow", bgackPullLow, mBg);
    checkBit("R7", "ownsBus", ownsBus, mBg);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rstN) compareModel();
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    step(3);
    // R1: reset state
    checkBit("R1", "brPullLow in reset", brPullLow, 1'b0);
    checkBit("R1", "bgackPullLow in reset", bgackPullLow, 1'b0);
    rstN = 1'b1;
    step(1);
    checkBit("R1", "ownsBus after reset", ownsBus, 1'b0);
    checkBit("R1", "brPullLow after reset", brPullLow, 1'b0);

    // R2: request appears one edge after reqIn
    reqIn = 1'b1;
    step(1);
    checkBit("R2", "request raised", brPullLow, 1'b1);
    step(3);
    // R9: withdraw before grant
    reqIn = 1'b0;
    step(1);
    checkBit("R9", "request withdrawn", brPullLow, 1'b0);
    checkBit("R9", "no claim", bgackPullLow, 1'b0);

    // R3: synchronizer latency on an idle bus
    reqIn = 1'b1;
    step(1);
    bgN = 1'b0;
    step(3);
    checkBit("R3", "no claim before fourth edge", bgackPullLow, 1'b0);
    step(1);
    checkBit("R3", "claim on fourth edge", bgackPullLow, 1'b1);
    checkBit("R6", "request still low-driven", brPullLow, 1'b1);
    step(1);
    checkBit("R6", "request released after claim", brPullLow, 1'b0);

    // R7: hold until done; mark bus busy for the re-request that follows
    asN = 1'b0;
    step(5);
    checkBit("R7", "held without done", ownsBus, 1'b1);
    doneIn = 1'b1;
    step(1);
    doneIn = 1'b0;
    checkBit("R7", "released on done", bgackPullLow, 1'b0);
    checkBit("R7", "owns dropped", ownsBus, 1'b0);
    // R8: gap before new request
    checkBit("R8", "no request at release", brPullLow, 1'b0);
    step(1);
    checkBit("R8", "no request one edge later", brPullLow, 1'b0);
    step(1);
    checkBit("R8", "request after gap", brPullLow, 1'b1);

    // R5: grant held while address strobe busy
    step(8);
    checkBit("R5", "no claim while strobe busy", bgackPullLow, 1'b0);
    otherBgack = 1'b1; asN = 1'b1;
    step(8);
    checkBit("R5", "no claim while other master holds", bgackPullLow, 1'b0);
    // R10: grant removed while waiting
    bgN = 1'b1;
    step(4);
    checkBit("R10", "request kept after grant loss", brPullLow, 1'b1);
    checkBit("R10", "no claim after grant loss", bgackPullLow, 1'b0);
    bgN = 1'b0; otherBgack = 1'b0;
    step(5);
    checkBit("R5", "claim once bus quiet", bgackPullLow, 1'b1);
    reqIn = 1'b0; doneIn = 1'b1;
    step(1);
    doneIn = 1'b0;
    step(3);
    checkBit("R7", "idle after release", ownsBus, 1'b0);

    // R11: two-wire mode
    bgN = 1'b1;
    step(4);
    twoWireMode = 1'b1;
    reqIn = 1'b1; bgN = 1'b0;
    step(6);
    checkBit("R11", "owning", bgackPullLow, 1'b1);
    checkBit("R11", "request held while owning", brPullLow, 1'b1);
    reqIn = 1'b0;
    step(3);
    checkBit("R11", "still held without request", brPullLow, 1'b1);
    doneIn = 1'b1;
    step(1);
    doneIn = 1'b0;
    checkBit("R11", "request falls with acknowledge", brPullLow, 1'b0);
    checkBit("R11", "acknowledge falls", bgackPullLow, 1'b0);

    // Random phase in both modes
    for (int mode = 0; mode < 2; mode++) begin
      reqIn = 1'b0; doneIn = 1'b0; bgN = 1'b1; asN = 1'b1; dtackN = 1'b1; otherBgack = 1'b0;
      step(8);
      twoWireMode = mode[0];
      for (int i = 0; i < 3000; i++) begin
        if ($urandom_range(7) == 0) reqIn = ~reqIn;
        doneIn = ($urandom_range(5) == 0);
        if ($urandom_range(4) == 0) bgN = ~bgN;
        if ($urandom_range(3) == 0) asN = ~asN;
        if ($urandom_range(3) == 0) dtackN = ~dtackN;
        otherBgack = !bgackPullLow && ($urandom_range(9) == 0);
        step(1);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule